// File: doc/BRIEF.md
# Transmit Queue with Threshold Interrupts and DMA Request

This block is a first-in, first-out store between the side that produces transmit words and the parallel bus engine that consumes them. Words arrive on a push port and leave on a show-ahead pop port. The head word is always on `pop_data`, and `pop_valid` marks it as real.

Beside the store sit a small set of configuration registers and the logic that watches the fill count. Three status conditions are derived from the count: full, empty, and at-or-below a programmable low-water mark. Each condition has its own enable bit, and the interrupt line is the OR of the enabled conditions. A second low-water mark, programmed independently of the first, drives a DMA request so that a DMA engine can refill the queue.

Software can flush the queue by writing a hold value into a flush register. The queue stays empty until that register is written back to zero.

Top module: `txq_level_fifo`

## Requirements
- R1: After reset, occupancy is 0 and `pop_valid`, `irq` and `dma_req` are low. All interrupt enables, both thresholds and the DMA enable are 0, so `raw_status` reads 3'b110.
- R2: Accepted words leave in the order they were pushed. While the queue is non-empty, `pop_data` shows the oldest word and `pop_valid` is high.
- R3: Occupancy never exceeds DEPTH (32). A push while full is dropped, and the stored words and their order are unchanged.
- R4: While the queue is empty, `pop_valid` is low and a pop request leaves occupancy at 0.
- R5: `raw_status` bit 0 is high when occupancy equals DEPTH, bit 1 when occupancy is 0, and bit 2 when occupancy is at or below the low-water level. The low-water level is written with `cfg_sel`=0 from `cfg_wdata[4:0]` and ranges from 0 to 31.
- R6: `irq` is the OR of the `raw_status` bits whose enable is set. It follows the current conditions and is not latched.
- R7: The enable register (bit order as in R5) can be written as a whole with `cfg_sel`=2, have bits set with `cfg_sel`=3 (OR with `cfg_wdata[2:0]`), or have bits cleared with `cfg_sel`=4 (AND with the inverse). It reads back on `irq_enable`.
- R8: Writing a non-zero value such as 0x07 with `cfg_sel`=5 holds the queue flushed. In the hold, occupancy goes to 0 on the next clock, `pop_valid` is low and pushes are dropped. Writing 0x00 with `cfg_sel`=5 releases it.
- R9: `cfg_sel`=1 sets the DMA level from `cfg_wdata[4:0]` and the DMA enable from `cfg_wdata[5]`. `dma_req` is high exactly when DMA is enabled and occupancy is at or below the DMA level.
- R10: A push and a pop accepted in the same cycle leave occupancy unchanged. Every accepted push or pop shows in `occupancy` after the next clock edge, and the status, interrupt and DMA outputs follow the registered occupancy with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Offer `push_data` for storage this cycle |
| push_data | input | 32 | Word to store |
| pop_req | input | 1 | Consume the head word this cycle |
| pop_data | output | 32 | Head word (show-ahead) |
| pop_valid | output | 1 | `pop_data` holds a stored word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (0..5) |
| cfg_wdata | input | 8 | Configuration write data |
| occupancy | output | 6 | Number of stored words |
| raw_status | output | 3 | {low-water, empty, full} conditions |
| irq_enable | output | 3 | Interrupt enable register |
| irq | output | 1 | OR of enabled status bits |
| dma_req | output | 1 | DMA refill request |

## Verification
The properties assume that `rst_n` is held low for at least one clock edge before any traffic. They also assume that `cfg_sel` carries only the six defined codes whenever `cfg_we` is high. The stimulus keeps to both rules: reset is held for several cycles, and every register write goes through one task that uses only the named codes. Inputs change only a short time after a rising edge and are held for a full cycle, so each push, pop or register write is seen by exactly one edge.

// File: rtl/txq_pkg.sv
// Package: shared constants and types for the transmit queue.
// Assumes: the queue depth is a power of two.
package txq_pkg;

    localparam int unsigned TXQ_DEPTH = 32;   // default number of entries
    localparam int unsigned TXQ_DW    = 32;   // default word width
    localparam int unsigned CFG_W     = 8;    // configuration write width
    localparam int unsigned NUM_SRC   = 3;    // interrupt sources

    // bit positions of the status vector
    localparam int unsigned ST_FULL  = 0;
    localparam int unsigned ST_EMPTY = 1;
    localparam int unsigned ST_LOW   = 2;

    // configuration register select codes
    typedef enum logic [2:0] {
        SEL_LOW_LVL = 3'd0,
        SEL_DMA     = 3'd1,
        SEL_IEN_WR  = 3'd2,
        SEL_IEN_SET = 3'd3,
        SEL_IEN_CLR = 3'd4,
        SEL_FLUSH   = 3'd5
    } cfg_sel_e;

endpackage

// File: rtl/txq_regs.sv
// Module: txq_regs
// Holds the configuration state: low-water level, DMA level and enable,
// interrupt enables and the flush register. Assumes one write per cycle;
// unknown select codes are ignored.
module txq_regs
    import txq_pkg::*;
#(
    parameter int unsigned LVL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [LVL_W-1:0]   low_lvl,
    output logic [LVL_W-1:0]   dma_lvl,
    output logic               dma_en,
    output logic [NUM_SRC-1:0] ien,
    output logic               flush_hold
);

    logic [CFG_W-1:0] flush_q;
    logic             unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    // register update on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_lvl <= '0;
            dma_lvl <= '0;
            dma_en  <= 1'b0;
            ien     <= '0;
            flush_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_LOW_LVL: low_lvl <= cfg_wdata[LVL_W-1:0];
                SEL_DMA: begin
                    dma_lvl <= cfg_wdata[LVL_W-1:0];
                    dma_en  <= cfg_wdata[LVL_W];
                end
                SEL_IEN_WR:  ien     <= cfg_wdata[NUM_SRC-1:0];
                SEL_IEN_SET: ien     <= ien | cfg_wdata[NUM_SRC-1:0];
                SEL_IEN_CLR: ien     <= ien & ~cfg_wdata[NUM_SRC-1:0];
                SEL_FLUSH:   flush_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // any non-zero flush value keeps the queue emptied
    assign flush_hold = (flush_q != '0);

endmodule

// File: rtl/txq_store.sv
// Module: txq_store
// Circular buffer with read/write pointers and a fill counter. Pushes when
// full and pops when empty are refused. A flush hold resets pointers and count.
// Assumes DEPTH is a power of two.
module txq_store #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_hold,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    // acceptance of each side
    always_comb begin
        push_ok = push_valid && (count != FULL_CNT) && !flush_hold;
        pop_ok  = pop_req && (count != '0) && !flush_hold;
    end

    // pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush_hold) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // show-ahead head word
    assign pop_data  = mem[rd_ptr];
    assign pop_valid = (count != '0) && !flush_hold;

endmodule

// File: rtl/txq_flags.sv
// Module: txq_flags
// Derives full, empty and low-water conditions from the fill count, masks
// them into the interrupt and compares against the DMA level. Purely
// combinational; the conditions are not latched.
module txq_flags
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH),
    localparam int unsigned CW    = LVL_W + 1
) (
    input  logic [CW-1:0]      count,
    input  logic [LVL_W-1:0]   low_lvl,
    input  logic [LVL_W-1:0]   dma_lvl,
    input  logic               dma_en,
    input  logic [NUM_SRC-1:0] ien,
    output logic [NUM_SRC-1:0] status,
    output logic               irq,
    output logic               dma_req
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [NUM_SRC-1:0] masked;

    // level conditions
    always_comb begin
        status           = '0;
        status[ST_FULL]  = (count == FULL_CNT);
        status[ST_EMPTY] = (count == '0);
        status[ST_LOW]   = (count <= {1'b0, low_lvl});
    end

    // per-source masking
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        assign masked[i] = status[i] & ien[i];
    end

    assign irq     = |masked;
    assign dma_req = dma_en && (count <= {1'b0, dma_lvl});

endmodule

// File: rtl/txq_level_fifo.sv
// Module: txq_level_fifo (top)
// Transmit queue with threshold interrupts, a DMA refill request and a
// register-held flush. Assumes a single clock and synchronous reset.
module txq_level_fifo
    import txq_pkg::*;
#(
    parameter int unsigned DW    = TXQ_DW,
    parameter int unsigned DEPTH = TXQ_DEPTH,
    localparam int unsigned LVL_W = $clog2(DEPTH),
    localparam int unsigned CW    = LVL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [DW-1:0]      push_data,
    input  logic               pop_req,
    output logic [DW-1:0]      pop_data,
    output logic               pop_valid,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CW-1:0]      occupancy,
    output logic [NUM_SRC-1:0] raw_status,
    output logic [NUM_SRC-1:0] irq_enable,
    output logic               irq,
    output logic               dma_req
);

    logic [LVL_W-1:0] low_lvl;
    logic [LVL_W-1:0] dma_lvl;
    logic             dma_en;
    logic             flush_hold;

    txq_regs #(.LVL_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .low_lvl    (low_lvl),
        .dma_lvl    (dma_lvl),
        .dma_en     (dma_en),
        .ien        (irq_enable),
        .flush_hold (flush_hold)
    );

    txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_hold (flush_hold),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop_req    (pop_req),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid),
        .count      (occupancy)
    );

    txq_flags #(.DEPTH(DEPTH)) u_flags (
        .count   (occupancy),
        .low_lvl (low_lvl),
        .dma_lvl (dma_lvl),
        .dma_en  (dma_en),
        .ien     (irq_enable),
        .status  (raw_status),
        .irq     (irq),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/txq_level_fifo_chk.sv
// Module: txq_level_fifo_chk
// Property checker bound to the top. Assumes reset is applied first.
module txq_level_fifo_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = 6,
    parameter int unsigned NSRC  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_valid,
    input logic            pop_req,
    input logic            pop_valid,
    input logic            flush_hold,
    input logic            dma_en,
    input logic [CW-1:0]   occupancy,
    input logic [NSRC-1:0] raw_status,
    input logic [NSRC-1:0] irq_enable,
    input logic            irq,
    input logic            dma_req
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= FULL_CNT);

    p_full_push_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == FULL_CNT && push_valid && !pop_req && !flush_hold)
        |=> occupancy == FULL_CNT);

    p_empty_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[1] |-> !pop_valid);

    p_empty_pop_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0 && pop_req && !push_valid) |=> occupancy == '0);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enable == '0) |-> !irq);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_hold |=> (occupancy == '0 && !pop_valid));

    p_dma_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(occupancy) |-> (occupancy == $past(occupancy) + CW'(1) ||
                                 occupancy + CW'(1) == $past(occupancy) ||
                                 occupancy == '0));

endmodule

bind txq_level_fifo txq_level_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .NSRC(txq_pkg::NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .flush_hold (flush_hold),
    .dma_en     (dma_en),
    .occupancy  (occupancy),
    .raw_status (raw_status),
    .irq_enable (irq_enable),
    .irq        (irq),
    .dma_req    (dma_req)
);

// File: tb/txq_level_fifo_tb.sv
// Scoreboard bench: driver tasks queue expected words, a monitor compares pops.
module txq_level_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid;
    logic [31:0] push_data;
    logic        pop_req;
    logic [31:0] pop_data;
    logic        pop_valid;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [5:0]  occupancy;
    logic [2:0]  raw_status;
    logic [2:0]  irq_enable;
    logic        irq;
    logic        dma_req;

    int          n_vec = 0;
    int          n_bad = 0;
    int          model_cnt = 0;
    bit          model_hold = 1'b0;
    bit          done = 1'b0;
    logic [31:0] sb[$];

    always #5 clk = ~clk;

    txq_level_fifo u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .occupancy(occupancy), .raw_status(raw_status), .irq_enable(irq_enable),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        if (sel == 3'd5) begin
            model_hold = (d != 8'h00);
            if (model_hold) begin sb.delete(); model_cnt = 0; end
        end
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] d);
        push_valid = 1'b1; push_data = d;
        if (model_cnt < 32 && !model_hold) begin sb.push_back(d); model_cnt++; end
        cyc();
        push_valid = 1'b0;
    endtask

    task automatic pop_word();
        pop_req = 1'b1;
        cyc();
        pop_req = 1'b0;
        if (model_cnt > 0 && !model_hold) model_cnt--;
    endtask

    // monitor: compare the head word against the scoreboard (R2, R4)
    always @(negedge clk) begin
        if (rst_n && pop_req) begin
            if (sb.size() == 0) check("R4 pop_valid on empty", {31'd0, pop_valid}, 32'd0);
            else begin
                check("R2 pop_valid", {31'd0, pop_valid}, 32'd1);
                check("R2 order", pop_data, sb[0]);
                void'(sb.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; push_valid = 1'b0; push_data = '0; pop_req = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 occupancy", {26'd0, occupancy}, 32'd0);
        check("R1 status", {29'd0, raw_status}, 32'h6);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 dma_req", {31'd0, dma_req}, 32'd0);
        check("R1 pop_valid", {31'd0, pop_valid}, 32'd0);

        // R4 pop on empty
        pop_word();
        check("R4 occupancy after empty pop", {26'd0, occupancy}, 32'd0);

        // R10 occupancy follows each push one edge later, R5 status
        for (int i = 0; i < 5; i++) push_word(32'hA000_0000 + i);
        check("R10 occupancy 5", {26'd0, occupancy}, 32'd5);
        check("R5 status mid", {29'd0, raw_status}, 32'h0);
        cfg(3'd0, 8'd5);
        check("R5 low-water at level", {29'd0, raw_status}, 32'h4);

        // R6 interrupt follows enabled level condition, not latched
        cfg(3'd2, 8'h4);
        check("R6 irq set", {31'd0, irq}, 32'd1);
        push_word(32'hA000_0005);
        check("R6 irq drops above level", {31'd0, irq}, 32'd0);

        // R7 set and clear operations
        cfg(3'd3, 8'h1);
        check("R7 set op", {29'd0, irq_enable}, 32'h5);
        cfg(3'd4, 8'h4);
        check("R7 clear op", {29'd0, irq_enable}, 32'h1);

        // R9 DMA request threshold
        cfg(3'd1, 8'h26);
        check("R9 dma at level", {31'd0, dma_req}, 32'd1);
        push_word(32'hA000_0006);
        check("R9 dma above level", {31'd0, dma_req}, 32'd0);
        cfg(3'd1, 8'h1F);
        check("R9 dma disabled", {31'd0, dma_req}, 32'd0);

        // R2 drain in order
        for (int i = 0; i < 7; i++) pop_word();
        check("R2 drained", {26'd0, occupancy}, 32'd0);

        // R3 fill to full, extra push dropped, contents intact
        for (int i = 0; i < 32; i++) push_word(32'h5A00_0000 ^ (i * 32'h0101_0101));
        check("R3 full occupancy", {26'd0, occupancy}, 32'd32);
        check("R5 full bit", {29'd0, raw_status}, 32'h1);
        check("R6 irq on full", {31'd0, irq}, 32'd1);
        push_word(32'hDEAD_BEEF);
        check("R3 push when full dropped", {26'd0, occupancy}, 32'd32);
        for (int i = 0; i < 32; i++) pop_word();
        check("R5 empty bit", {29'd0, raw_status}, 32'h6);

        // R10 simultaneous push and pop
        push_word(32'h1111_0001);
        push_word(32'h1111_0002);
        push_valid = 1'b1; push_data = 32'h1111_0003; pop_req = 1'b1;
        sb.push_back(32'h1111_0003);
        cyc();
        push_valid = 1'b0; pop_req = 1'b0;
        check("R10 push+pop keeps count", {26'd0, occupancy}, 32'd2);

        // R8 flush hold and release
        cfg(3'd5, 8'h07);
        check("R8 pop_valid in hold", {31'd0, pop_valid}, 32'd0);
        cyc();
        check("R8 flushed", {26'd0, occupancy}, 32'd0);
        push_word(32'h2222_0000);
        check("R8 push dropped in hold", {26'd0, occupancy}, 32'd0);
        cfg(3'd5, 8'h00);
        push_word(32'h3333_0001);
        check("R8 released push accepted", {26'd0, occupancy}, 32'd1);
        pop_word();
        check("R8 released drain", {26'd0, occupancy}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule